// File: doc/BRIEF.md
# Descriptor-List Bus-Master DMA Engine

This block moves data between system memory and a disk-channel data FIFO without processor involvement per word. Software builds a table of region descriptors in memory, programs the table base register, clears stale status, and writes a start command that selects the direction. The engine then walks the table. For each entry it fetches two 32-bit words through a single-outstanding memory request port, unpacks the region address, byte count and flags, and moves the region one 32-bit beat at a time. It finishes after the entry whose end flag is set.

Three registers form the host view: command (offset 0), status (offset 1) and table base (offset 2). Completion raises the interrupt status bit, which drives `irq`. A memory response error raises both the error and interrupt bits and halts the engine. Writing a command with the run bit clear stops the engine from any state.

The engine is one state machine with states IDLE, FETCH_ADDR, FETCH_CNT, MEM_RD, DEV_PUSH, DEV_PULL and MEM_WR. These transitions are defined:
- IDLE→FETCH_ADDR on a start command.
- FETCH_ADDR→FETCH_CNT on a good response.
- FETCH_CNT→MEM_RD for memory-to-device, or FETCH_CNT→DEV_PULL for device-to-memory.
- MEM_RD→DEV_PUSH on a good response.
- DEV_PULL→MEM_WR when a FIFO word is taken.
- DEV_PUSH or MEM_WR, at the end of a beat, go to the next beat (MEM_RD or DEV_PULL), to FETCH_ADDR for the next entry, or to IDLE after the final entry.
- Any fetch or memory state goes to IDLE on a response error.
- Every state goes to IDLE on a stop command.

Top module: `prd_dma_ctrl`

## Requirements
- R1: After reset, all three registers read 0, `irq` is low and the engine is idle.
- R2: The table base register (offset 2) stores bits [31:4] of a write. Bits [3:0] always read 0, so the table is 16-byte aligned.
- R3: In the command register (offset 0), bit 0 is run and bit 3 is direction. A write with bit 0 = 1 while idle starts the engine: bit 3 = 1 moves device to memory, bit 3 = 0 moves memory to device. A write with bit 0 = 0 is a stop.
- R4: The status register (offset 1) is laid out as follows. Bit 0 is active and read-only. Bit 1 is error and bit 2 is interrupt; both are cleared by writing 1, and writing 0 leaves them unchanged. Bits 5 and 6 are the drive 0 and drive 1 capability flags, plain read/write. `irq` equals bit 2.
- R5: Descriptor n sits at base+8n as two little-endian memory words, with the byte at the lowest address in bits [7:0]. Word 0 is the region address. In word 1, bits [15:0] are the byte count and bits [31:16] are flags. Only flag bit 15 (word bit 31), the end flag, has a meaning.
- R6: A byte count of 0 means a region of 65536 bytes.
- R7: In memory-to-device mode, the region is read in ascending word order and each word is presented on the device output in the same order.
- R8: In device-to-memory mode, each word accepted from the device input is written to consecutive ascending memory addresses of the region.
- R9: After the last beat of the entry with the end flag set, the engine goes idle, sets the interrupt bit and fetches no further descriptor.
- R10: A stop returns the engine to idle at any time, does not set the interrupt bit and ends device traffic. A stop while idle changes nothing in status.
- R11: A memory response with the error flag set causes three things: the error and interrupt bits are set, the engine goes idle, and no further beats move.
- R12: The active status bit reads 1 from the start command until the engine returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 table base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt status bit |
| mem_req | output | 1 | Memory request, held until a response |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory response strobe |
| mem_rsp_data | input | 32 | Read response data |
| mem_rsp_err | input | 1 | Response carries a fault |
| dev_out_valid | output | 1 | Word offered to the device FIFO |
| dev_out_data | output | 32 | Word to the device |
| dev_out_ready | input | 1 | Device FIFO accepts the word |
| dev_in_valid | input | 1 | Device FIFO offers a word |
| dev_in_data | input | 32 | Word from the device |
| dev_in_ready | output | 1 | Engine takes the offered word |

## Verification
The hardest situations to reach are the ones in the middle of a long walk. One is a stop that lands while beats of a 65536-byte region are still flowing. Another is a memory fault on a data beat, which must not come from a descriptor fetch. The bench builds tables with a zero count so that a single entry runs for tens of thousands of cycles, issues the stop at a fixed point inside it, and then checks that the device stream stays frozen. A fault address is planted on the third beat of a region, which proves that exactly two words reached the device before the halt.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_FETCH_ADDR, S_FETCH_CNT, S_MEM_RD, S_DEV_PUSH, S_DEV_PULL, S_MEM_WR
    } eng_state_t;

    localparam logic [1:0] REG_CMD  = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_BASE = 2'd2;

    localparam int CMD_RUN  = 0;
    localparam int CMD_DIR  = 3;
    localparam int ST_ACT   = 0;
    localparam int ST_ERR   = 1;
    localparam int ST_INT   = 2;
    localparam int ST_CAP0  = 5;
    localparam int ST_CAP1  = 6;
    localparam int FLAG_END = 15;

    localparam int CNT_W = 16;

    function automatic logic [CNT_W:0] region_bytes(input logic [CNT_W-1:0] cnt);
        return (cnt == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt};
    endfunction
endpackage

// File: rtl/prd_dma_regs.sv
module prd_dma_regs
    import prd_dma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              set_err,
    input  logic              set_int,
    output logic              start_pulse,
    output logic              start_dir,
    output logic              stop_pulse,
    output logic [ADDR_W-1:0] table_base,
    output logic              irq
);
    logic [ADDR_W-5:0] base_q;
    logic err_q, int_q, cap0_q, cap1_q, run_q, dir_q;
    logic wr_cmd, wr_stat, wr_base;

    assign wr_cmd  = reg_wr && (reg_addr == REG_CMD);
    assign wr_stat = reg_wr && (reg_addr == REG_STAT);
    assign wr_base = reg_wr && (reg_addr == REG_BASE);

    assign start_pulse = wr_cmd && reg_wdata[CMD_RUN] && !busy;
    assign start_dir   = reg_wdata[CMD_DIR];
    assign stop_pulse  = wr_cmd && !reg_wdata[CMD_RUN];
    assign table_base  = {base_q, 4'b0000};
    assign irq         = int_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            err_q  <= 1'b0;
            int_q  <= 1'b0;
            cap0_q <= 1'b0;
            cap1_q <= 1'b0;
            run_q  <= 1'b0;
            dir_q  <= 1'b0;
        end else begin
            if (wr_base) base_q <= reg_wdata[ADDR_W-1:4];
            if (wr_cmd) begin
                run_q <= reg_wdata[CMD_RUN];
                dir_q <= reg_wdata[CMD_DIR];
            end
            if (wr_stat) begin
                cap0_q <= reg_wdata[ST_CAP0];
                cap1_q <= reg_wdata[ST_CAP1];
            end
            if (set_err) err_q <= 1'b1;
            else if (wr_stat && reg_wdata[ST_ERR]) err_q <= 1'b0;
            if (set_int) int_q <= 1'b1;
            else if (wr_stat && reg_wdata[ST_INT]) int_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            REG_CMD: begin
                reg_rdata[CMD_RUN] = run_q;
                reg_rdata[CMD_DIR] = dir_q;
            end
            REG_STAT: begin
                reg_rdata[ST_ACT]  = busy;
                reg_rdata[ST_ERR]  = err_q;
                reg_rdata[ST_INT]  = int_q;
                reg_rdata[ST_CAP0] = cap0_q;
                reg_rdata[ST_CAP1] = cap1_q;
            end
            REG_BASE: reg_rdata[ADDR_W-1:0] = table_base;
            default:  reg_rdata = '0;
        endcase
    end

    // R9: interrupt rises only together with the engine going idle
    p_int_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_q) |-> !busy);
    // R10: a stop command leaves the engine idle on the next cycle
    p_stop_idles_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !busy);
    // R4: a clear-by-one write without a new event drops the error bit
    p_err_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[ST_ERR] && !set_err) |=> !err_q);
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
    import prd_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_dir,
    input  logic              stop,
    input  logic [ADDR_W-1:0] table_base,
    output logic              busy,
    output logic              set_err,
    output logic              set_int,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    input  logic              dev_in_valid,
    input  logic [DATA_W-1:0] dev_in_data,
    output logic              dev_in_ready
);
    localparam int BEAT = DATA_W / 8;
    localparam int DESC_BYTES = 2 * BEAT;

    eng_state_t state_q, state_d;
    logic [ADDR_W-1:0] desc_q, bufp_q;
    logic [CNT_W:0]    rem_q;
    logic              last_q, dir_q;
    logic [DATA_W-1:0] word_q;
    logic rsp_ok, err_ev, beat_done, region_end;

    assign rsp_ok     = mem_req && mem_rsp_valid && !mem_rsp_err;
    assign err_ev     = mem_req && mem_rsp_valid && mem_rsp_err && !stop;
    assign beat_done  = (state_q == S_DEV_PUSH && dev_out_ready) ||
                        (state_q == S_MEM_WR && rsp_ok);
    assign region_end = (rem_q <= (CNT_W+1)'(BEAT));

    always_comb begin
        state_d = state_q;
        if (stop) state_d = S_IDLE;
        else if (err_ev) state_d = S_IDLE;
        else begin
            unique case (state_q)
                S_IDLE:       if (start) state_d = S_FETCH_ADDR;
                S_FETCH_ADDR: if (rsp_ok) state_d = S_FETCH_CNT;
                S_FETCH_CNT:  if (rsp_ok) state_d = dir_q ? S_DEV_PULL : S_MEM_RD;
                S_MEM_RD:     if (rsp_ok) state_d = S_DEV_PUSH;
                S_DEV_PULL:   if (dev_in_valid) state_d = S_MEM_WR;
                S_DEV_PUSH, S_MEM_WR:
                    if (beat_done) begin
                        if (!region_end) state_d = dir_q ? S_DEV_PULL : S_MEM_RD;
                        else if (last_q) state_d = S_IDLE;
                        else             state_d = S_FETCH_ADDR;
                    end
                default:      state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
            bufp_q <= '0;
            rem_q  <= '0;
            last_q <= 1'b0;
            dir_q  <= 1'b0;
            word_q <= '0;
        end else begin
            if (state_q == S_IDLE && start) begin
                desc_q <= table_base;
                dir_q  <= start_dir;
            end
            if (state_q == S_FETCH_ADDR && rsp_ok) bufp_q <= mem_rsp_data[ADDR_W-1:0];
            if (state_q == S_FETCH_CNT && rsp_ok) begin
                rem_q  <= region_bytes(mem_rsp_data[CNT_W-1:0]);
                last_q <= mem_rsp_data[CNT_W + FLAG_END];
                desc_q <= desc_q + ADDR_W'(DESC_BYTES);
            end
            if (state_q == S_MEM_RD && rsp_ok) word_q <= mem_rsp_data;
            if (state_q == S_DEV_PULL && dev_in_valid) word_q <= dev_in_data;
            if (beat_done) begin
                bufp_q <= bufp_q + ADDR_W'(BEAT);
                rem_q  <= region_end ? '0 : rem_q - (CNT_W+1)'(BEAT);
            end
        end
    end

    always_comb begin
        busy          = (state_q != S_IDLE);
        mem_req       = (state_q == S_FETCH_ADDR) || (state_q == S_FETCH_CNT) ||
                        (state_q == S_MEM_RD) || (state_q == S_MEM_WR);
        mem_we        = (state_q == S_MEM_WR);
        mem_addr      = (state_q == S_FETCH_ADDR) ? desc_q :
                        (state_q == S_FETCH_CNT)  ? desc_q + ADDR_W'(BEAT) : bufp_q;
        mem_wdata     = word_q;
        dev_out_valid = (state_q == S_DEV_PUSH);
        dev_out_data  = word_q;
        dev_in_ready  = (state_q == S_DEV_PULL);
        set_err       = err_ev;
        set_int       = err_ev || (beat_done && region_end && last_q && !stop);
    end

    // R7: a pending memory request holds its address until answered
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid && !stop) |=> (mem_req && $stable(mem_addr)));
    // R7: an offered device word stays put until taken
    p_push_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_out_valid && !dev_out_ready && !stop) |=> (dev_out_valid && $stable(dev_out_data)));
    // R5: descriptor fetches land on 8-byte boundaries
    p_desc_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FETCH_ADDR) |-> (mem_addr[2:0] == 3'b000));
    // R11: a faulted response halts the engine
    p_err_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_ev |=> !busy);
    // R6: remaining count never exceeds the largest region
    p_rem_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rem_q <= {1'b1, {CNT_W{1'b0}}}));
    // R3: only one direction handshake is ever open
    p_one_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_out_valid, dev_in_ready, mem_req}));
endmodule

// File: rtl/prd_dma_ctrl.sv
module prd_dma_ctrl
    import prd_dma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              dev_out_valid,
    output logic [31:0]       dev_out_data,
    input  logic              dev_out_ready,
    input  logic              dev_in_valid,
    input  logic [31:0]       dev_in_data,
    output logic              dev_in_ready
);
    logic busy, set_err, set_int, start_pulse, start_dir, stop_pulse;
    logic [ADDR_W-1:0] table_base;

    prd_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .set_err(set_err), .set_int(set_int), .start_pulse(start_pulse),
        .start_dir(start_dir), .stop_pulse(stop_pulse), .table_base(table_base),
        .irq(irq)
    );

    prd_dma_engine #(.ADDR_W(ADDR_W), .DATA_W(32)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(start_pulse), .start_dir(start_dir),
        .stop(stop_pulse), .table_base(table_base), .busy(busy),
        .set_err(set_err), .set_int(set_int), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_ready(dev_out_ready), .dev_in_valid(dev_in_valid),
        .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready)
    );
endmodule

// File: tb/test_prd_dma_ctrl.sv
module test_prd_dma_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq, mem_req, mem_we, dev_out_valid, dev_in_ready;
    logic [31:0] mem_addr, mem_wdata, dev_out_data;
    logic mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic mem_rsp_err = 1'b0;
    logic dev_out_ready = 1'b1;
    logic dev_in_valid = 1'b0;
    logic [31:0] dev_in_data = '0;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] got [$];
    logic [31:0] err_addr = 32'hFFFF_FFF0;
    int in_cnt = 0;

    always #4 clk = ~clk;

    prd_dma_ctrl i_prd_dma_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_ready(dev_out_ready), .dev_in_valid(dev_in_valid),
        .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] rd_mem(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return pat(a);
    endfunction

    // memory model: answers one cycle after a request appears
    always @(posedge clk) begin
        if (mem_req && !mem_rsp_valid) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_err   <= (mem_addr == err_addr);
            mem_rsp_data  <= rd_mem(mem_addr);
            if (mem_we && mem_addr != err_addr) mem[mem_addr] = mem_wdata;
        end else begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_err   <= 1'b0;
        end
    end

    // device model
    always @(posedge clk) begin
        if (dev_out_valid && dev_out_ready) got.push_back(dev_out_data);
        if (dev_in_valid && dev_in_ready) begin
            in_cnt      <= in_cnt + 1;
            dev_in_data <= 32'hC0DE_0000 + 32'(in_cnt + 1);
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 100000; i++) begin
            rd(2'd1, s);
            if (!s[0]) break;
        end
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] a, input logic [15:0] cnt, input logic [15:0] fl);
        mem[at]     = a;
        mem[at + 4] = {fl, cnt};
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); check(v == 0, "R1 cmd reset", v, 0);
        rd(2'd1, v); check(v == 0, "R1 status reset", v, 0);
        rd(2'd2, v); check(v == 0, "R1 base reset", v, 0);
        check(irq == 0, "R1 irq reset", {31'b0, irq}, 0);
    endtask

    task automatic t_base();
        logic [31:0] v;
        wr(2'd2, 32'h0001_003F);
        rd(2'd2, v); check(v == 32'h0001_0030, "R2 base aligned", v, 32'h0001_0030);
    endtask

    task automatic t_stop_idle();
        logic [31:0] v;
        wr(2'd1, 32'h60);
        rd(2'd1, v); check(v == 32'h60, "R4 capability bits rw", v, 32'h60);
        wr(2'd0, 32'h0);
        rd(2'd1, v); check(v == 32'h60, "R10 stop when idle harmless", v, 32'h60);
    endtask

    task automatic t_mem_to_dev();
        logic [31:0] v;
        logic [31:0] exp [$];
        put_desc(32'h1000, 32'h2000, 16'd16, 16'h7FFF);
        put_desc(32'h1008, 32'h3000, 16'd8,  16'h8000);
        put_desc(32'h1010, 32'h4000, 16'd4,  16'h8000);
        got.delete();
        wr(2'd1, 32'h66);
        wr(2'd2, 32'h1000);
        wr(2'd0, 32'h01);
        rd(2'd1, v); check(v[0] == 1, "R12 active while running", v, 32'h1);
        wait_idle();
        for (int i = 0; i < 4; i++) exp.push_back(pat(32'h2000 + 32'(4*i)));
        for (int i = 0; i < 2; i++) exp.push_back(pat(32'h3000 + 32'(4*i)));
        check(got.size() == 6, "R9 R5 word count stops at end flag", 32'(got.size()), 6);
        for (int i = 0; i < 6 && i < got.size(); i++)
            check(got[i] == exp[i], "R7 device word order", got[i], exp[i]);
        rd(2'd1, v); check(v == 32'h64, "R9 int set active clear", v, 32'h64);
        check(irq == 1, "R4 irq follows int", {31'b0, irq}, 1);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(2'd1, 32'h26);
        rd(2'd1, v); check(v == 32'h20, "R4 clear by one", v, 32'h20);
    endtask

    task automatic t_dev_to_mem();
        logic [31:0] v;
        put_desc(32'h5000, 32'h6000, 16'd12, 16'h8000);
        in_cnt = 0;
        dev_in_data = 32'hC0DE_0000;
        dev_in_valid = 1'b1;
        wr(2'd2, 32'h5000);
        wr(2'd0, 32'h09);
        wait_idle();
        dev_in_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            v = rd_mem(32'h6000 + 32'(4*i));
            check(v == 32'hC0DE_0000 + 32'(i), "R8 R3 device to memory", v, 32'hC0DE_0000 + 32'(i));
        end
        v = rd_mem(32'h600C);
        check(v == pat(32'h600C), "R8 no write past region", v, pat(32'h600C));
        rd(2'd1, v); check(v == 32'h24, "R9 read-mode completion", v, 32'h24);
        wr(2'd1, 32'h06);
    endtask

    task automatic t_big();
        logic [31:0] v;
        put_desc(32'h7000, 32'h10000, 16'd0, 16'h8000);
        got.delete();
        wr(2'd2, 32'h7000);
        wr(2'd0, 32'h01);
        wait_idle();
        check(got.size() == 16384, "R6 zero count is 65536 bytes", 32'(got.size()), 16384);
        if (got.size() > 0)
            check(got[got.size()-1] == pat(32'h1FFFC), "R6 last word", got[got.size()-1], pat(32'h1FFFC));
        wr(2'd1, 32'h06);
    endtask

    task automatic t_stop_run();
        logic [31:0] v;
        int n;
        put_desc(32'h8000, 32'h20000, 16'd0, 16'h8000);
        got.delete();
        wr(2'd2, 32'h8000);
        wr(2'd0, 32'h01);
        repeat (100) @(negedge clk);
        wr(2'd0, 32'h00);
        rd(2'd1, v); check(v == 32'h0, "R10 stop mid-run idles without int", v, 32'h0);
        n = got.size();
        repeat (50) @(negedge clk);
        check(got.size() == n, "R10 traffic ends after stop", 32'(got.size()), 32'(n));
        check(n > 0 && n < 16384, "R10 stop landed mid-region", 32'(n), 32'd1);
    endtask

    task automatic t_err();
        logic [31:0] v;
        put_desc(32'h9000, 32'h30000, 16'd32, 16'h8000);
        err_addr = 32'h30008;
        got.delete();
        wr(2'd2, 32'h9000);
        wr(2'd0, 32'h01);
        wait_idle();
        rd(2'd1, v); check(v == 32'h06, "R11 fault sets err and int", v, 32'h06);
        check(got.size() == 2, "R11 no beats after fault", 32'(got.size()), 2);
        repeat (20) @(negedge clk);
        check(got.size() == 2, "R11 engine stays halted", 32'(got.size()), 2);
        wr(2'd1, 32'h06);
        rd(2'd1, v); check(v == 32'h0, "R4 err and int cleared", v, 32'h0);
        err_addr = 32'hFFFF_FFF0;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_base();
        t_stop_idle();
        t_mem_to_dev();
        t_w1c();
        t_dev_to_mem();
        t_big();
        t_stop_run();
        t_err();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule